// File: doc/BRIEF.md
# Burst ROM Read Cycle Controller

This block sequences read cycles to a ROM or flash device hanging off a local bus. A requester offers a byte address, a burst flag and a beat count over a valid/ready handshake. The controller then drives the device address, a chip select and a read command. It counts out the programmed wait states and pulses a data-valid strobe once per beat. When a burst is requested, it steps the low four address bits from one beat to the next.

Two wait-state counts are used. The first count times the opening beat of every cycle. The second count times each later beat of a burst. A configuration bit picks how the chip select is formed. In early mode it follows the address window alone, so it rises one clock before the read command, and the first countdown starts in that clock. In qualified mode it rises together with the read command. A second configuration bit adds one cycle to every beat to cover external data buffers. An input from the bus can stretch any beat once its countdown has run out.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its request fields stable until then. The data-valid strobe has no back-pressure: the consumer must take the data in the clock it is flagged. Stalls come only from `bus_ready`.

Top module: `burst_rom_rdctl`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. `busy` rises on the clock after acceptance and stays high through the final beat's data-valid clock. A `req_valid` raised while busy is not taken and produces no beat.
- R2: In qualified mode, the clock after acceptance is a lead clock in which the address is driven and both `rom_cs` and `rom_rd` are low. The first beat then spends first-wait + buffer-delay + 1 clocks with `rom_rd` high, and its data-valid pulse falls in the last of these clocks.
- R3: In early mode, `rom_cs` is already high in the lead clock for an in-window address, while `rom_rd` stays low. The first countdown begins in the lead clock, so the first beat spends max(first-wait + buffer-delay, 1) clocks with `rom_rd` high.
- R4: Each later beat of a burst spends next-wait + buffer-delay + 1 clocks, so with both counts at zero every burst address is held for exactly one clock.
- R5: On each later beat, the address bits [3:0] advance by one modulo 16 (0xF is followed by 0x0). The bits above bit 3 keep the accepted value for the whole cycle.
- R6: Once a beat's countdown has expired, a low `bus_ready` holds the beat. `beat_valid` pulses in the first clock in which `bus_ready` is high. A low `bus_ready` during the countdown has no effect on timing.
- R7: When `cfg_buf_delay` is 1, every beat, first and later, is one clock longer than with 0.
- R8: With `req_burst` low, exactly one beat is run, whatever `req_beats` holds. With `req_burst` high, `req_beats` + 1 beats are run (field value 0 to 15 gives 1 to 16 beats).
- R9: `rom_cs` is high only while the address bits [AW-1:AW-2] equal the window code (default 2'b11). For an address outside the window, the cycle still runs with `rom_rd` and `beat_valid` as usual, but `rom_cs` stays low.
- R10: In the clock after the final beat's data-valid pulse, `rom_cs`, `rom_rd` and `busy` are all low and `req_ready` is high.
- R11: The two wait counts, the early-mode bit and the buffer-delay bit are sampled at acceptance. Changing them while busy does not alter the running cycle.
- R12: After reset, `busy`, `rom_cs`, `rom_rd` and `beat_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW | Starting byte address |
| req_burst | input | 1 | Request is a burst to a burst-mode device |
| req_beats | input | BCW | Beat count minus one (used only for bursts) |
| cfg_early_cs | input | 1 | 1: chip select from address alone; 0: qualified by read command |
| cfg_wait_first | input | WSW | Extra clocks for the first beat |
| cfg_wait_next | input | WSW | Extra clocks for each later burst beat |
| cfg_buf_delay | input | 1 | Adds one clock to every beat |
| bus_ready | input | 1 | Device ready; low stretches an expired beat |
| rom_addr | output | AW | Address driven to the device |
| rom_cs | output | 1 | Chip select, active high |
| rom_rd | output | 1 | Read command, active high |
| beat_valid | output | 1 | One-clock data-valid strobe per beat |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest case to reach is the interaction of `bus_ready` with the countdown. A stall must stretch a beat only after its wait states are spent, and data must be taken in the same clock that ready returns. The stimulus holds `bus_ready` low from before acceptance for a chosen number of clocks. In one run the stall outlasts a zero-wait countdown. In the other it ends inside a three-clock countdown and must leave the timing untouched. A further hard case is a request offered while a long burst is running. The driver raises `req_valid` with a different address just after acceptance, and the scoreboard flags any beat that it did not expect.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_BEAT = 2'd2
  } brc_state_e;
endpackage

// File: rtl/brc_wait_timer.sv
`timescale 1ns/1ps
// Down-counter for the wait states of one beat; load wins over decrement.
module brc_wait_timer #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            dec,
  output logic            zero
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - CNTW'(1);
  end

  assign zero = (cnt_q == '0);

  // R4: an expired countdown stays expired until the next load
  p_zero_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero && !load |=> zero);
endmodule

// File: rtl/brc_addr_step.sv
`timescale 1ns/1ps
// Holds the device address; steps only the low bits, wrapping inside the line.
module brc_addr_step #(
  parameter int AW       = 24,
  parameter int LOW_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-LOW_BITS-1:0] hi_q;
  logic [LOW_BITS-1:0]    lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      hi_q <= load_addr[AW-1:LOW_BITS];
      lo_q <= load_addr[LOW_BITS-1:0];
    end else if (step) begin
      lo_q <= lo_q + LOW_BITS'(1);
    end
  end

  assign addr = {hi_q, lo_q};

  // R5: upper bits never move between loads
  p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr[AW-1:LOW_BITS]));
endmodule

// File: rtl/brc_cs_decode.sv
`timescale 1ns/1ps
// Window decode of the chip select, optionally qualified by the read command.
module brc_cs_decode #(
  parameter int                  AW       = 24,
  parameter int                  WIN_BITS = 2,
  parameter logic [WIN_BITS-1:0] WIN_SEL  = '1
) (
  input  logic [AW-1:0] addr,
  input  logic          active,
  input  logic          cmd,
  input  logic          early,
  output logic          cs
);
  logic hit;
  assign hit = (addr[AW-1 -: WIN_BITS] == WIN_SEL);
  assign cs  = hit && active && (early || cmd);
endmodule

// File: rtl/burst_rom_rdctl.sv
`timescale 1ns/1ps
module burst_rom_rdctl
  import brc_pkg::*;
#(
  parameter int                  AW       = 24,
  parameter int                  WSW      = 3,
  parameter int                  BCW      = 4,
  parameter int                  LOW_BITS = 4,
  parameter int                  WIN_BITS = 2,
  parameter logic [WIN_BITS-1:0] WIN_SEL  = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_burst,
  input  logic [BCW-1:0] req_beats,
  input  logic           cfg_early_cs,
  input  logic [WSW-1:0] cfg_wait_first,
  input  logic [WSW-1:0] cfg_wait_next,
  input  logic           cfg_buf_delay,
  input  logic           bus_ready,
  output logic [AW-1:0]  rom_addr,
  output logic           rom_cs,
  output logic           rom_rd,
  output logic           beat_valid,
  output logic           busy
);
  localparam int CNTW = WSW + 1;

  brc_state_e     state_q, state_d;
  logic           early_q, xtra_q;
  logic [WSW-1:0] wnext_q;
  logic [BCW-1:0] left_q;

  logic            accept, beat_done, last_beat, tmr_zero;
  logic            tmr_load, tmr_dec;
  logic [CNTW-1:0] tmr_val;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rom_rd    = (state_q == ST_BEAT);
  assign last_beat = (left_q == '0);
  assign beat_done = rom_rd && tmr_zero && bus_ready;
  assign beat_valid = beat_done;

  // first count on acceptance, next count when a non-final beat ends
  assign tmr_load = accept || (beat_done && !last_beat);
  assign tmr_val  = accept ? (CNTW'(cfg_wait_first) + CNTW'(cfg_buf_delay))
                           : (CNTW'(wnext_q) + CNTW'(xtra_q));
  // early decode: the countdown already runs in the lead clock
  assign tmr_dec  = rom_rd || ((state_q == ST_LEAD) && early_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LEAD;
      ST_LEAD: state_d = ST_BEAT;
      ST_BEAT: if (beat_done && last_beat) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      early_q <= 1'b0;
      xtra_q  <= 1'b0;
      wnext_q <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        early_q <= cfg_early_cs;
        xtra_q  <= cfg_buf_delay;
        wnext_q <= cfg_wait_next;
        left_q  <= req_burst ? req_beats : '0;
      end else if (beat_done && !last_beat) begin
        left_q  <= left_q - BCW'(1);
      end
    end
  end

  brc_wait_timer #(.CNTW(CNTW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  brc_addr_step #(.AW(AW), .LOW_BITS(LOW_BITS)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .step      (beat_done && !last_beat),
    .addr      (rom_addr)
  );

  brc_cs_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .WIN_SEL(WIN_SEL)) i_cs (
    .addr   (rom_addr),
    .active (busy),
    .cmd    (rom_rd),
    .early  (early_q),
    .cs     (rom_cs)
  );

  // R1: an accepted request makes the block busy on the next clock
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R6: data is flagged only while the command is up and the bus is ready
  p_valid_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (rom_rd && bus_ready));
  // R10: after the final beat the bus is released
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && last_beat |=> (!rom_cs && !rom_rd && !busy));
  // R2: in qualified mode the chip select never leads the read command
  p_qual_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs && !early_q |-> rom_rd);
endmodule

// File: tb/test_burst_rom_rdctl.sv
`timescale 1ns/1ps
module test_burst_rom_rdctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_beats = '0;
  logic        cfg_early_cs = 1'b0;
  logic [2:0]  cfg_wait_first = '0;
  logic [2:0]  cfg_wait_next = '0;
  logic        cfg_buf_delay = 1'b0;
  logic        bus_ready = 1'b1;
  logic [23:0] rom_addr;
  logic        rom_cs, rom_rd, beat_valid, busy;

  always #2 clk = ~clk;

  burst_rom_rdctl i_burst_rom_rdctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .req_beats(req_beats),
    .cfg_early_cs(cfg_early_cs), .cfg_wait_first(cfg_wait_first),
    .cfg_wait_next(cfg_wait_next), .cfg_buf_delay(cfg_buf_delay),
    .bus_ready(bus_ready), .rom_addr(rom_addr), .rom_cs(rom_cs),
    .rom_rd(rom_rd), .beat_valid(beat_valid), .busy(busy)
  );

  typedef struct {
    logic [23:0] addr;
    int          gap;
    bit          cs;
    bit          last;
    string       tag;
  } item_t;

  item_t q[$];
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  int  n = 0;
  int  last_evt = 0;
  int  lead_at = -1;
  int  tail_at = -1;
  bit  lead_cs_exp = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected beats and checks timing, address and strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n++;
      if (n == lead_at) begin
        chk(rom_cs == lead_cs_exp, "R2/R3 lead chip select", int'(rom_cs), int'(lead_cs_exp));
        chk(!rom_rd && busy, "R2 lead read low, busy high", int'({rom_rd, busy}), 1);
      end
      if (n == tail_at)
        chk(!rom_cs && !rom_rd && !busy && req_ready, "R10 release after last beat",
            int'({rom_cs, rom_rd, busy, req_ready}), 1);
      if (beat_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected beat", int'(rom_addr), -1);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(rom_addr == it.addr, {it.tag, " R5 address"}, int'(rom_addr), int'(it.addr));
          chk(n - last_evt == it.gap, {it.tag, " beat timing"}, n - last_evt, it.gap);
          chk(rom_cs == it.cs && rom_rd, {it.tag, " R9 select/read"},
              int'({rom_cs, rom_rd}), int'({it.cs, 1'b1}));
          if (it.last) tail_at = n + 1;
        end
        last_evt = n;
      end
      if (req_valid && req_ready) begin
        last_evt = n;
        lead_at  = n + 1;
      end
    end
  end

  task automatic run_req(input logic [23:0] addr, input bit burst, input int beats,
                         input bit early, input int w1, input int w2, input int x,
                         input int stall, input int gap_first, input bit poke,
                         input string tag);
    int  nb;
    int  first;
    bit  hit;
    item_t it;
    while (busy) begin @(posedge clk); #1; end
    nb    = burst ? beats + 1 : 1;
    hit   = (addr[23:22] == 2'b11);
    first = early ? (((w1 + x) == 0) ? 1 : (w1 + x)) : (w1 + x + 1);
    for (int i = 0; i < nb; i++) begin
      it.addr = {addr[23:4], 4'(int'(addr[3:0]) + i)};
      it.gap  = (i == 0) ? ((gap_first != 0) ? gap_first : 1 + first) : (w2 + x + 1);
      it.cs   = hit;
      it.last = (i == nb - 1);
      it.tag  = tag;
      q.push_back(it);
    end
    lead_cs_exp    = hit && early;
    req_addr       = addr;
    req_burst      = burst;
    req_beats      = 4'(beats);
    cfg_early_cs   = early;
    cfg_wait_first = 3'(w1);
    cfg_wait_next  = 3'(w2);
    cfg_buf_delay  = x[0];
    bus_ready      = (stall == 0);
    req_valid      = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    // R11: scramble the configuration once the request is taken
    cfg_early_cs   = ~early;
    cfg_wait_first = 3'd7;
    cfg_wait_next  = 3'd7;
    cfg_buf_delay  = ~x[0];
    if (poke) begin
      // R1: offer a second request while busy
      req_addr  = 24'hC00300;
      req_burst = 1'b0;
      req_valid = 1'b1;
      repeat (2) @(posedge clk);
      #1 req_valid = 1'b0;
    end
    if (stall != 0) begin
      repeat (stall) @(posedge clk);
      #1 bus_ready = 1'b1;
    end
    while (busy) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    #1;
    chk(q.size() == 0, {tag, " all beats seen"}, q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk(!busy && req_ready && !rom_cs && !rom_rd && !beat_valid, "R12 reset outputs",
        int'({busy, req_ready, rom_cs, rom_rd, beat_valid}), 8);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R2: qualified single read, first wait 2
    run_req(24'hC00010, 0, 0, 0, 2, 0, 0, 0, 0, 0, "R2");
    // R3: early decode, wait 2 and wait 0
    run_req(24'hC00020, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R3");
    run_req(24'hC00024, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3");
    // R3/R7: early decode with buffer delay and maximum wait
    run_req(24'hC00028, 0, 0, 1, 7, 0, 1, 0, 0, 0, "R7");
    // R4 R5 R8: qualified burst of 4 wrapping 0xE -> 0x1
    run_req(24'hC0001E, 1, 3, 0, 1, 0, 0, 0, 0, 0, "R4");
    // R7: early burst with buffer delay on every beat
    run_req(24'hC00040, 1, 1, 1, 0, 2, 1, 0, 0, 0, "R7");
    // R8: non-burst ignores the beat count field
    run_req(24'hC00050, 0, 5, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: outside the window, no chip select
    run_req(24'h400020, 1, 1, 0, 0, 1, 0, 0, 0, 0, "R9");
    // R6: stall outlasting a zero-wait countdown
    run_req(24'hC00060, 0, 0, 0, 0, 0, 0, 4, 5, 0, "R6");
    // R6: stall ending inside a 3-clock countdown has no effect
    run_req(24'hC00070, 0, 0, 0, 3, 0, 0, 2, 5, 0, "R6");
    // R1 R5 R11: full 16-beat burst with a request offered while busy
    run_req(24'hC00085, 1, 15, 0, 0, 0, 0, 0, 0, 1, "R1");
    chk(!busy && req_ready, "R1 poked request not taken", int'({busy, req_ready}), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule